// File: doc/BRIEF.md
# Charge-First Authentication Attempt Guard

This block sequences one side of a mutual challenge-response authentication and keeps a persistent attempt counter honest. A reader starts an attempt by presenting its response authenticator. Before any secret-dependent work begins, the block writes the decremented counter back to persistent storage and waits for the storage to acknowledge the write. Only then does it ask an external cipher to compute the authenticator pair. One part of that pair checks the reader and the other part goes back to the reader. The block compares the reader's authenticator with the computed reader part. It then writes the final counter and the refreshed nonce, and reports pass or fail.

Because the penalty is committed first, a reset pulse or a supply drop taken while the key is being processed cannot erase the charged attempt. Only a verified success puts the counter back to its full value. When too many failures have accumulated, the block refuses further attempts and never starts the cipher for them. The persistent memory and the cipher sit outside the block and are reached through a write/acknowledge port and a request/valid port.

Top module: `auth_attempt_guard`

## Requirements
- R1: On an accepted request, the first storage write carries the stored counter minus one with the nonce-write flag low. The cipher request stays low until that write is acknowledged.
- R2: On success the final write sets the counter to 0xFF. It sets the nonce to byte 0 = 0xFF followed by the seven tag bytes from the cipher, where byte 0 is the most significant byte of the nonce bus and tag byte 0 is the most significant byte of the tag bus.
- R3: On failure the final write keeps the counter at the pre-attempt value minus one. Nonce byte 0 (most significant) becomes that counter value and nonce bytes 1 to 7 are unchanged.
- R4: An attempt passes exactly when the reader authenticator captured with the request equals the cipher's reader part over the full width. A difference in any single chunk makes it fail.
- R5: A reset asserted after the charge write has been acknowledged leaves the stored counter at the charged (decremented) value, and the block returns to idle.
- R6: The lock output is high whenever the stored counter is at or below 0xFF minus MAX_FAILS (0xFC for three). A request while locked ends with a done pulse in the next cycle and pass low. It causes no storage write and no cipher request, and leaves the nonce untouched.
- R7: A failed final write that leaves the counter at or below the lock level sets a sticky lock. The lock stays high until reset, even if the stored counter later reads full.
- R8: A storage write request holds its counter and nonce-write flag stable until it is acknowledged.
- R9: The cipher request stays high until valid. The reader and tag parts are captured in the cycle valid is seen.
- R10: After reset, busy, done, pass, the storage write and the cipher request are all low. Every request ends with a done pulse exactly one cycle long.
- R11: Start requests that arrive while an attempt is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset of volatile state |
| start_i | input | 1 | Attempt request, sampled while idle |
| rdr_auth_i | input | AUTH_W | Reader response authenticator |
| cnt_rd_i | input | CNT_W | Counter value currently held in storage |
| nonce_rd_i | input | NONCE_BYTES*CNT_W | Nonce currently held in storage |
| store_wr_o | output | 1 | Storage write request |
| store_cnt_o | output | CNT_W | Counter value to write |
| store_nonce_we_o | output | 1 | Nonce is written along with the counter |
| store_nonce_o | output | NONCE_BYTES*CNT_W | Nonce value to write |
| store_ack_i | input | 1 | Storage commit acknowledge |
| ciph_req_o | output | 1 | Cipher compute request |
| ciph_valid_i | input | 1 | Cipher result valid |
| ciph_rdr_i | input | AUTH_W | Computed authenticator checking the reader |
| ciph_tag_i | input | (NONCE_BYTES-1)*CNT_W | Leading bytes of the computed authenticator returned to the reader |
| busy_o | output | 1 | Attempt in progress |
| done_o | output | 1 | One-cycle end-of-request pulse |
| pass_o | output | 1 | Result of the last request |
| lock_o | output | 1 | Further attempts refused |

## Verification
The bench builds the block with the chunked comparator (16-bit chunks over a 64-bit authenticator) and a failure limit of three. The multi-cycle compare path therefore gets exercised, including mismatches confined to the first or the last chunk. The small failure limit means lockout is reached within three failures, whether through completed attempts or through resets taken during the cipher wait. That leaves room to exercise the sticky flag against a storage value that reads full again. Storage and cipher latencies are drawn at random, so the charge-before-cipher order is checked under varying handshake timing.

// File: rtl/aag_pkg.sv
package aag_pkg;
   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_CHARGE  = 3'd1,
      ST_COMPUTE = 3'd2,
      ST_COMPARE = 3'd3,
      ST_UPDATE  = 3'd4
   } aag_state_e;
endpackage

// File: rtl/aag_verify.sv
module aag_verify #(
   parameter int AUTH_W  = 64,
   parameter int CHUNK_W = 8,
   parameter bit SERIAL  = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              start_i,
   input  logic [AUTH_W-1:0] a_i,
   input  logic [AUTH_W-1:0] b_i,
   output logic              done_o,
   output logic              match_o
);
   localparam int N_CHUNK = AUTH_W / CHUNK_W;
   localparam int IDX_W   = (N_CHUNK > 1) ? $clog2(N_CHUNK) : 1;

   if (CHUNK_W < 1 || (AUTH_W % CHUNK_W) != 0) begin : g_bad_chunk
      $error("aag_verify: AUTH_W must be a multiple of CHUNK_W");
   end

   if (!SERIAL) begin : g_parallel
      logic done_q, match_q;
      always_ff @(posedge clk_i) begin
         if (rst_i) begin
            done_q  <= 1'b0;
            match_q <= 1'b0;
         end else begin
            done_q <= start_i;
            if (start_i) match_q <= (a_i == b_i);
         end
      end
      assign done_o  = done_q;
      assign match_o = match_q;
   end else begin : g_serial
      logic             busy_q, done_q, match_q, acc_q;
      logic [IDX_W-1:0] idx_q;
      logic             chunk_eq;

      assign chunk_eq = (a_i[idx_q*CHUNK_W +: CHUNK_W] == b_i[idx_q*CHUNK_W +: CHUNK_W]);

      always_ff @(posedge clk_i) begin
         if (rst_i) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            match_q <= 1'b0;
            acc_q   <= 1'b0;
            idx_q   <= '0;
         end else begin
            done_q <= 1'b0;
            if (start_i) begin
               busy_q <= 1'b1;
               acc_q  <= 1'b1;
               idx_q  <= '0;
            end else if (busy_q) begin
               acc_q <= acc_q & chunk_eq;
               if (idx_q == IDX_W'(N_CHUNK-1)) begin
                  busy_q  <= 1'b0;
                  done_q  <= 1'b1;
                  match_q <= acc_q & chunk_eq;
               end else begin
                  idx_q <= idx_q + IDX_W'(1);
               end
            end
         end
      end
      assign done_o  = done_q;
      assign match_o = match_q;

      // R4: operands must not move while chunks are being walked
      p_ops_stable_r4: assert property (@(posedge clk_i) disable iff (rst_i)
         busy_q |-> ($stable(a_i) && $stable(b_i)));
   end
endmodule

// File: rtl/aag_nonce_next.sv
module aag_nonce_next #(
   parameter int CNT_W       = 8,
   parameter int NONCE_BYTES = 8
) (
   input  logic                           pass_i,
   input  logic [CNT_W-1:0]               cnt_i,
   input  logic [NONCE_BYTES*CNT_W-1:0]   old_i,
   input  logic [(NONCE_BYTES-1)*CNT_W-1:0] tag_i,
   output logic [NONCE_BYTES*CNT_W-1:0]   nonce_o
);
   localparam int NONCE_W = NONCE_BYTES * CNT_W;
   localparam int TAIL_W  = NONCE_W - CNT_W;
   localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

   if (NONCE_BYTES < 2) begin : g_bad_len
      $error("aag_nonce_next: nonce needs at least two bytes");
   end

   always_comb begin
      if (pass_i) nonce_o = {FULL, tag_i};
      else        nonce_o = {cnt_i, old_i[TAIL_W-1:0]};
   end
endmodule

// File: rtl/aag_lock.sv
module aag_lock #(
   parameter int CNT_W     = 8,
   parameter int MAX_FAILS = 3
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [CNT_W-1:0] stored_cnt_i,
   input  logic             commit_i,
   input  logic [CNT_W-1:0] commit_cnt_i,
   output logic             lock_o
);
   localparam logic [CNT_W-1:0] LOCK_LVL = CNT_W'((1 << CNT_W) - 1 - MAX_FAILS);

   if (MAX_FAILS < 1 || MAX_FAILS >= (1 << CNT_W)) begin : g_bad_fails
      $error("aag_lock: MAX_FAILS out of range for CNT_W");
   end

   logic lock_q;
   always_ff @(posedge clk_i) begin
      if (rst_i) lock_q <= 1'b0;
      else if (commit_i && (commit_cnt_i <= LOCK_LVL)) lock_q <= 1'b1;
   end

   assign lock_o = lock_q | (stored_cnt_i <= LOCK_LVL);

   // R7: once latched the lock output stays up until reset
   p_lock_hold_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      lock_q |=> lock_o);
endmodule

// File: rtl/auth_attempt_guard.sv
module auth_attempt_guard
   import aag_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int NONCE_BYTES = 8,
   parameter int AUTH_W      = 64,
   parameter int MAX_FAILS   = 3,
   parameter bit SERIAL_CMP  = 1'b0,
   parameter int CMP_CHUNK   = 8
) (
   input  logic                             clk_i,
   input  logic                             rst_i,
   input  logic                             start_i,
   input  logic [AUTH_W-1:0]                rdr_auth_i,
   input  logic [CNT_W-1:0]                 cnt_rd_i,
   input  logic [NONCE_BYTES*CNT_W-1:0]     nonce_rd_i,
   output logic                             store_wr_o,
   output logic [CNT_W-1:0]                 store_cnt_o,
   output logic                             store_nonce_we_o,
   output logic [NONCE_BYTES*CNT_W-1:0]     store_nonce_o,
   input  logic                             store_ack_i,
   output logic                             ciph_req_o,
   input  logic                             ciph_valid_i,
   input  logic [AUTH_W-1:0]                ciph_rdr_i,
   input  logic [(NONCE_BYTES-1)*CNT_W-1:0] ciph_tag_i,
   output logic                             busy_o,
   output logic                             done_o,
   output logic                             pass_o,
   output logic                             lock_o
);
   localparam int NONCE_W = NONCE_BYTES * CNT_W;
   localparam int TAG_W   = NONCE_W - CNT_W;
   localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

   aag_state_e         st_q;
   logic [CNT_W-1:0]   cnt_dec_q;
   logic [AUTH_W-1:0]  rdr_q, ar_q;
   logic [TAG_W-1:0]   tag_q;
   logic [NONCE_W-1:0] nonce_q, nonce_next;
   logic               pass_q, done_q, verdict_q, charged_q, vstart_q;
   logic               v_done, v_match, lock_w, fail_commit;

   // ---------------- comparator (variant chosen by SERIAL_CMP)
   aag_verify #(.AUTH_W(AUTH_W), .CHUNK_W(CMP_CHUNK), .SERIAL(SERIAL_CMP)) u_verify (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .start_i (vstart_q),
      .a_i     (rdr_q),
      .b_i     (ar_q),
      .done_o  (v_done),
      .match_o (v_match)
   );

   // ---------------- nonce refresh
   aag_nonce_next #(.CNT_W(CNT_W), .NONCE_BYTES(NONCE_BYTES)) u_nonce (
      .pass_i  (verdict_q),
      .cnt_i   (cnt_dec_q),
      .old_i   (nonce_q),
      .tag_i   (tag_q),
      .nonce_o (nonce_next)
   );

   // ---------------- lockout
   assign fail_commit = (st_q == ST_UPDATE) && store_ack_i && !verdict_q;

   aag_lock #(.CNT_W(CNT_W), .MAX_FAILS(MAX_FAILS)) u_lock (
      .clk_i        (clk_i),
      .rst_i        (rst_i),
      .stored_cnt_i (cnt_rd_i),
      .commit_i     (fail_commit),
      .commit_cnt_i (cnt_dec_q),
      .lock_o       (lock_w)
   );

   // ---------------- sequencer
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         st_q      <= ST_IDLE;
         cnt_dec_q <= '0;
         rdr_q     <= '0;
         ar_q      <= '0;
         tag_q     <= '0;
         nonce_q   <= '0;
         pass_q    <= 1'b0;
         done_q    <= 1'b0;
         verdict_q <= 1'b0;
         charged_q <= 1'b0;
         vstart_q  <= 1'b0;
      end else begin
         done_q   <= 1'b0;
         vstart_q <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  pass_q <= 1'b0;
                  if (lock_w) begin
                     done_q <= 1'b1;
                  end else begin
                     cnt_dec_q <= cnt_rd_i - CNT_W'(1);
                     rdr_q     <= rdr_auth_i;
                     nonce_q   <= nonce_rd_i;
                     st_q      <= ST_CHARGE;
                  end
               end
            end
            ST_CHARGE: begin
               if (store_ack_i) begin
                  charged_q <= 1'b1;
                  st_q      <= ST_COMPUTE;
               end
            end
            ST_COMPUTE: begin
               if (ciph_valid_i) begin
                  ar_q     <= ciph_rdr_i;
                  tag_q    <= ciph_tag_i;
                  vstart_q <= 1'b1;
                  st_q     <= ST_COMPARE;
               end
            end
            ST_COMPARE: begin
               if (v_done) begin
                  verdict_q <= v_match;
                  st_q      <= ST_UPDATE;
               end
            end
            ST_UPDATE: begin
               if (store_ack_i) begin
                  done_q    <= 1'b1;
                  pass_q    <= verdict_q;
                  charged_q <= 1'b0;
                  st_q      <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      store_wr_o       = (st_q == ST_CHARGE) || (st_q == ST_UPDATE);
      store_nonce_we_o = (st_q == ST_UPDATE);
      store_cnt_o      = ((st_q == ST_UPDATE) && verdict_q) ? FULL : cnt_dec_q;
      store_nonce_o    = (st_q == ST_UPDATE) ? nonce_next : nonce_q;
   end

   assign ciph_req_o = (st_q == ST_COMPUTE);
   assign busy_o     = (st_q != ST_IDLE);
   assign done_o     = done_q;
   assign pass_o     = pass_q;
   assign lock_o     = lock_w;

   // ---------------- properties
   // R1: no cipher work before the charge is committed
   p_charge_first_r1: assert property (@(posedge clk_i) disable iff (rst_i)
      ciph_req_o |-> charged_q);
   // R8: write request and its data held until acknowledged
   p_write_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      (store_wr_o && !store_ack_i) |=>
         (store_wr_o && $stable(store_cnt_o) && $stable(store_nonce_we_o)));
   // R9: cipher request held until valid
   p_cipher_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      (ciph_req_o && !ciph_valid_i) |=> ciph_req_o);
   // R10: done is a single-cycle pulse
   p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (rst_i)
      done_o |=> !done_o);
   // R6: a locked request ends at once with no side effects
   p_locked_reject_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      (start_i && !busy_o && lock_o) |=> (done_o && !pass_o && !store_wr_o && !ciph_req_o));
endmodule

// File: tb/sim_auth_attempt_guard.sv
`timescale 1ns/1ps
module sim_auth_attempt_guard;
   localparam int CNT_W = 8, NB = 8, AW = 64, NW = 64, TW = 56;

   logic          clk = 1'b0, rst = 1'b1;
   logic          start = 1'b0, ack = 1'b0, cvalid = 1'b0;
   logic [AW-1:0] rdr = '0, c_rdr = '0;
   logic [TW-1:0] c_tag = '0;
   logic [7:0]    mem_cnt = 8'hFF;
   logic [NW-1:0] mem_nonce = 64'h0123_4567_89AB_CDEF;
   logic          st_wr, st_nwe, creq, busy, done, pass, lock;
   logic [7:0]    st_cnt;
   logic [NW-1:0] st_nonce;

   always #2.5 clk = ~clk;

   auth_attempt_guard #(.CNT_W(CNT_W), .NONCE_BYTES(NB), .AUTH_W(AW), .MAX_FAILS(3),
                        .SERIAL_CMP(1'b1), .CMP_CHUNK(16)) u0 (
      .clk_i(clk), .rst_i(rst), .start_i(start), .rdr_auth_i(rdr),
      .cnt_rd_i(mem_cnt), .nonce_rd_i(mem_nonce),
      .store_wr_o(st_wr), .store_cnt_o(st_cnt), .store_nonce_we_o(st_nwe),
      .store_nonce_o(st_nonce), .store_ack_i(ack),
      .ciph_req_o(creq), .ciph_valid_i(cvalid), .ciph_rdr_i(c_rdr), .ciph_tag_i(c_tag),
      .busy_o(busy), .done_o(done), .pass_o(pass), .lock_o(lock));

   int checks = 0, failures = 0;
   int wr_count = 0, creq_seen = 0;
   bit cipher_early = 0, mute = 0, bench_lock = 0;
   logic [7:0]    first_wr_cnt = '0;
   logic          first_wr_nwe = 1'b0;
   logic [AW-1:0] next_ar = '0;
   logic [TW-1:0] next_at = '0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // storage model
   initial begin
      int d = 0;
      forever begin
         @(negedge clk);
         if (ack) ack = 1'b0;
         else if (st_wr) begin
            if (d > 0) d--;
            else begin
               ack = 1'b1;
               if (wr_count == 0) begin first_wr_cnt = st_cnt; first_wr_nwe = st_nwe; end
               mem_cnt = st_cnt;
               if (st_nwe) mem_nonce = st_nonce;
               wr_count++;
               d = $urandom % 3;
            end
         end
      end
   end

   // cipher model
   initial begin
      int d = 0;
      forever begin
         @(negedge clk);
         if (cvalid) cvalid = 1'b0;
         else if (creq) begin
            creq_seen++;
            if (wr_count == 0) cipher_early = 1;
            if (!mute) begin
               if (d > 0) d--;
               else begin
                  cvalid = 1'b1; c_rdr = next_ar; c_tag = next_at; d = $urandom % 4;
               end
            end
         end
      end
   end

   function automatic bit exp_locked();
      return bench_lock || (mem_cnt <= 8'hFC);
   endfunction

   task automatic attempt(input logic [AW-1:0] reader, input logic [AW-1:0] ar,
                          input logic [TW-1:0] at, input bit poke, input string tag);
      logic [7:0]    b_cnt = mem_cnt, e_cnt;
      logic [NW-1:0] b_nonce = mem_nonce, e_nonce;
      bit lk = exp_locked();
      bit e_pass = !lk && (reader == ar);
      e_cnt   = lk ? b_cnt : (e_pass ? 8'hFF : b_cnt - 8'd1);
      e_nonce = lk ? b_nonce : (e_pass ? {8'hFF, at} : {b_cnt - 8'd1, b_nonce[55:0]});
      @(negedge clk);
      wr_count = 0; creq_seen = 0; cipher_early = 0;
      next_ar = ar; next_at = at;
      start = 1'b1; rdr = reader;
      @(negedge clk);
      start = 1'b0; rdr = ~reader;
      if (poke && !lk) begin
         @(negedge clk);
         start = 1'b1; rdr = ar;   // R11: ignored while busy
         @(negedge clk);
         start = 1'b0;
      end
      while (!done) @(negedge clk);
      check(pass == e_pass, lk ? "R6" : "R4", {tag, " pass"}, 64'(pass), 64'(e_pass));
      check(mem_cnt == e_cnt, lk ? "R6" : (e_pass ? "R2" : "R3"), {tag, " counter"}, 64'(mem_cnt), 64'(e_cnt));
      check(mem_nonce == e_nonce, lk ? "R6" : (e_pass ? "R2" : "R3"), {tag, " nonce"}, mem_nonce, e_nonce);
      if (lk) begin
         check(wr_count == 0 && creq_seen == 0, "R6", {tag, " side effects"}, 64'(wr_count + creq_seen), 64'd0);
      end else begin
         check(wr_count == 2, "R11", {tag, " write count"}, 64'(wr_count), 64'd2);
         check(first_wr_cnt == b_cnt - 8'd1 && !first_wr_nwe && !cipher_early, "R1",
               {tag, " charge write"}, {first_wr_nwe, cipher_early, first_wr_cnt}, {2'b00, b_cnt - 8'd1});
         if (!e_pass && e_cnt <= 8'hFC) bench_lock = 1;
      end
      @(negedge clk);
      check(!done, "R10", {tag, " done width"}, 64'(done), 64'd0);
      check(lock == exp_locked(), lk ? "R6" : "R7", {tag, " lock"}, 64'(lock), 64'(exp_locked()));
   endtask

   task automatic do_reset();
      rst = 1'b1; mute = 0;
      repeat (3) @(negedge clk);
      rst = 1'b0; bench_lock = 0;
      @(negedge clk);
   endtask

   task automatic reset_mid(input string tag);
      logic [7:0] b_cnt = mem_cnt;
      @(negedge clk);
      mute = 1; wr_count = 0;
      start = 1'b1; rdr = 64'h5555;
      @(negedge clk);
      start = 1'b0;
      while (!creq) @(negedge clk);
      repeat (2) @(negedge clk);
      do_reset();
      check(mem_cnt == b_cnt - 8'd1, "R5", {tag, " charged count kept"}, 64'(mem_cnt), 64'(b_cnt - 8'd1));
      check(!busy && !creq && !st_wr, "R5", {tag, " idle after reset"}, {busy, creq, st_wr}, 64'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [AW-1:0] k;
      logic [TW-1:0] t;
      void'($urandom(32'd1207));
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check(!busy && !done && !pass && !st_wr && !creq, "R10", "reset state",
            {busy, done, pass, st_wr, creq}, 64'd0);
      check(!lock, "R6", "unlocked at full count", 64'(lock), 64'd0);

      // directed
      k = {$urandom, $urandom}; t = {$urandom, $urandom};
      attempt(k, k, t, 0, "match");
      attempt(k, k ^ 64'h1, t, 0, "lsb mismatch");
      attempt(k, k ^ 64'h8000_0000_0000_0000, t, 1, "msb mismatch poked");
      attempt(k, k, ~t, 1, "match poked");

      // random
      for (int i = 0; i < 24; i++) begin
         bit m = ($urandom % 2) || (mem_cnt <= 8'hFD);
         k = {$urandom, $urandom}; t = {$urandom, $urandom};
         attempt(k, m ? k : k ^ (64'h1 << ($urandom % 64)), t, ($urandom % 3) == 0, "random");
      end

      // three failures in a row latch the lock
      k = {$urandom, $urandom};
      attempt(k, k, t, 0, "refill");
      for (int i = 0; i < 3; i++) attempt(k, ~k, t, 0, "fail run");
      attempt(k, k, t, 0, "locked match");
      mem_cnt = 8'hFF;
      @(negedge clk);
      check(lock == 1'b1, "R7", "sticky with full store", 64'(lock), 64'd1);
      attempt(k, k, t, 0, "sticky reject");
      do_reset();
      check(lock == 1'b0, "R7", "cleared by reset", 64'(lock), 64'd0);

      // resets during the cipher wait still charge
      reset_mid("mid1");
      reset_mid("mid2");
      reset_mid("mid3");
      check(lock == 1'b1, "R6", "locked after charged resets", 64'(lock), 64'd1);
      attempt(k, k, t, 0, "reject after resets");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule